// File: doc/BRIEF.md
# Pipeline General-Purpose Register File with Write-Through Read

This block is the integer register file of a five-stage in-order pipeline. It holds 32 registers of 32 bits. The decode stage uses it through two read ports, one for each source operand. The write-back stage uses it through one write port. Both reads are combinational. A write is committed on the rising clock edge.

Decode and write-back can name the same register in the same cycle. When they do, the read returns the value being written in that cycle instead of the stale stored one, so the two stages never conflict. Register 0 is a constant zero. A synchronous, active-high reset makes every register read as zero without clearing the storage array, which keeps that array free of reset logic.

Top module: `gpr_file`

## Requirements
- R1: A read of register 0 returns 0 on either port at all times.
- R2: A write addressed to register 0 has no effect. This holds in the same cycle (read data stays 0) and later (register 0 still reads 0).
- R3: With `wr_en` = 1 and a nonzero `wr_addr`, `wr_data` is stored at the rising clock edge. Later reads of that register return it until it is written again.
- R4: With `wr_en` = 0, no register changes, whatever `wr_addr` and `wr_data` hold.
- R5: If `wr_en` = 1, `wr_addr` is nonzero and a read address equals `wr_addr`, that read port returns `wr_data` in the same cycle.
- R6: Forwarding is decided per port. A port whose address differs from `wr_addr` returns the stored value while the other port is forwarding.
- R7: After a clock edge with `rst` = 1, every register reads 0. A write presented in a cycle with `rst` = 1 is discarded.
- R8: When both read addresses are equal, both ports return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Register number for operand port A |
| rd_addr_b | input | 5 | Register number for operand port B |
| wr_addr | input | 5 | Register number written by write-back |
| wr_data | input | 32 | Value written by write-back |
| wr_en | input | 1 | Write enable |
| rd_data_a | output | 32 | Operand A value |
| rd_data_b | output | 32 | Operand B value |

## Verification
The hardest case to reach is a same-cycle write and read where the two ports disagree. In that case one port must forward the incoming word while the other returns a stored word. The stored word may be an overwritten value or the zero left by reset. The stimulus first fills a register and then rewrites it while reading it on one port and a different register on the other port. It then writes register 0 while reading it on both ports. Finally it reasserts reset together with a pending write and reads back the written registers, which must now be zero.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned DEF_NUM_REGS = 32;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_NUM_RD   = 2;
endpackage

// File: rtl/gpr_store.sv
// Storage array: no reset, one write port and NUM_RD asynchronous read ports.
module gpr_store #(
  parameter int unsigned NUM_REGS = gpr_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = gpr_pkg::DEF_DATA_W,
  parameter int unsigned NUM_RD   = gpr_pkg::DEF_NUM_RD,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              waddr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  raddr,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/gpr_valid.sv
// One flag per register; cleared by reset, set by a committed write.
module gpr_valid #(
  parameter int unsigned NUM_REGS = gpr_pkg::DEF_NUM_REGS,
  parameter int unsigned NUM_RD   = gpr_pkg::DEF_NUM_RD,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             waddr,
  input  logic [NUM_RD-1:0][ADDR_W-1:0] raddr,
  output logic [NUM_RD-1:0]             rvalid
);
  logic [NUM_REGS-1:0] flags;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else if (we) flags[waddr] <= 1'b1;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rv
    assign rvalid[p] = flags[raddr[p]];
  end
endmodule

// File: rtl/gpr_bypass.sv
// Per-port result select: zero register, same-cycle forward, or stored word.
module gpr_bypass #(
  parameter int unsigned DATA_W = gpr_pkg::DEF_DATA_W,
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] raddr,
  input  logic [DATA_W-1:0] stored,
  input  logic              stored_ok,
  input  logic              fwd_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic is_zero_reg;
  logic hit;

  assign is_zero_reg = (raddr == '0);
  assign hit         = fwd_en && (raddr == waddr);

  always_comb begin
    if (is_zero_reg)    rdata = '0;
    else if (hit)       rdata = wdata;
    else if (stored_ok) rdata = stored;
    else                rdata = '0;
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int unsigned NUM_REGS = gpr_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = gpr_pkg::DEF_DATA_W,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
  localparam int unsigned NUM_RD  = gpr_pkg::DEF_NUM_RD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);
  logic                          wr_live;
  logic                          wr_commit;
  logic [NUM_RD-1:0][ADDR_W-1:0] raddr;
  logic [NUM_RD-1:0][DATA_W-1:0] stored;
  logic [NUM_RD-1:0]             stored_ok;
  logic [NUM_RD-1:0][DATA_W-1:0] result;

  assign wr_live   = wr_en && (wr_addr != '0);
  assign wr_commit = wr_live && !rst;
  assign raddr[0]  = rd_addr_a;
  assign raddr[1]  = rd_addr_b;

  gpr_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_store (
    .clk(clk), .we(wr_commit), .waddr(wr_addr), .wdata(wr_data),
    .raddr(raddr), .rdata(stored)
  );

  gpr_valid #(.NUM_REGS(NUM_REGS), .NUM_RD(NUM_RD)) u_valid (
    .clk(clk), .rst(rst), .we(wr_commit), .waddr(wr_addr),
    .raddr(raddr), .rvalid(stored_ok)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    gpr_bypass #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_byp (
      .raddr(raddr[p]), .stored(stored[p]), .stored_ok(stored_ok[p]),
      .fwd_en(wr_live), .waddr(wr_addr), .wdata(wr_data), .rdata(result[p])
    );
  end

  assign rd_data_a = result[0];
  assign rd_data_b = result[1];
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_en,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [DATA_W-1:0] rd_data_b
);
  // R1
  zero_reg_a_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0) |-> (rd_data_a == '0));
  // R1
  zero_reg_b_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == '0) |-> (rd_data_b == '0));
  // R5
  fwd_a_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0 && rd_addr_a == wr_addr) |-> (rd_data_a == wr_data));
  // R5
  fwd_b_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0 && rd_addr_b == wr_addr) |-> (rd_data_b == wr_data));
  // R3
  commit_a_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0) |=>
      ((rd_addr_a == $past(wr_addr) && !(wr_en && wr_addr == rd_addr_a))
        -> (rd_data_a == $past(wr_data))));
  // R4
  hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == rd_addr_a) |=>
      (($stable(rd_addr_a) && !(wr_en && wr_addr == rd_addr_a)) -> $stable(rd_data_a)));
  // R8
  same_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));
endmodule

bind gpr_file gpr_file_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
  .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
);

// File: tb/sim_gpr_file.sv
module sim_gpr_file;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [31:0] ea;
    logic [31:0] eb;
  } vec_t;

  // Applied in order after reset; expectations follow R1-style rules per row comment.
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd5,  32'hA5A5_0001, 5'd5,  5'd6,  32'hA5A5_0001, 32'h0},          // R5 fwd, R7 zero
    '{1'b0, 5'd5,  32'hFFFF_FFFF, 5'd5,  5'd5,  32'hA5A5_0001, 32'hA5A5_0001}, // R3, R8
    '{1'b1, 5'd0,  32'hDEAD_BEEF, 5'd0,  5'd0,  32'h0,         32'h0},          // R2, R1
    '{1'b0, 5'd0,  32'h0,         5'd0,  5'd5,  32'h0,         32'hA5A5_0001}, // R2
    '{1'b1, 5'd31, 32'h1234_5678, 5'd5,  5'd31, 32'hA5A5_0001, 32'h1234_5678}, // R6
    '{1'b1, 5'd31, 32'h8765_4321, 5'd31, 5'd31, 32'h8765_4321, 32'h8765_4321}, // R5
    '{1'b0, 5'd31, 32'h0BAD_0BAD, 5'd31, 5'd1,  32'h8765_4321, 32'h0},          // R4
    '{1'b1, 5'd1,  32'h0000_0011, 5'd1,  5'd31, 32'h0000_0011, 32'h8765_4321}, // R6
    '{1'b1, 5'd2,  32'h0000_0022, 5'd1,  5'd2,  32'h0000_0011, 32'h0000_0022}, // R3
    '{1'b0, 5'd2,  32'hFFFF_FFFF, 5'd2,  5'd1,  32'h0000_0022, 32'h0000_0011}, // R4
    '{1'b1, 5'd1,  32'h0,         5'd1,  5'd2,  32'h0,         32'h0000_0022}, // R5
    '{1'b0, 5'd0,  32'h0,         5'd1,  5'd31, 32'h0,         32'h8765_4321}  // R3
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic [31:0] wr_data;
  logic        wr_en;
  logic [31:0] rd_data_a, rd_data_b;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  gpr_file u0 (
    .clk(clk), .rst(rst), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R7: reset state, no write pending
    drive(1'b0, 5'd0, 32'h0, 5'd7, 5'd31);
    #1;
    check("R7 reset port A", rd_data_a, 32'h0);
    check("R7 reset port B", rd_data_b, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].we, VEC[i].wa, VEC[i].wd, VEC[i].ra, VEC[i].rb);
      #1;
      check($sformatf("R1-table row %0d port A", i), rd_data_a, VEC[i].ea);
      check($sformatf("R1-table row %0d port B", i), rd_data_b, VEC[i].eb);
    end

    // R7: reset with a pending write; the write must be dropped
    @(negedge clk);
    rst = 1'b1;
    drive(1'b1, 5'd7, 32'h0000_0077, 5'd1, 5'd2);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 5'd0, 32'h0, 5'd7, 5'd31);
    #1;
    check("R7 write during reset dropped", rd_data_a, 32'h0);
    check("R7 reg31 cleared", rd_data_b, 32'h0);
    @(negedge clk);
    drive(1'b0, 5'd0, 32'h0, 5'd5, 5'd2);
    #1;
    check("R7 reg5 cleared", rd_data_a, 32'h0);
    check("R7 reg2 cleared", rd_data_b, 32'h0);

    // R2: register 0 still zero after an earlier write to it
    @(negedge clk);
    drive(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
    @(negedge clk);
    drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    #1;
    check("R2 reg0 after write", rd_data_a, 32'h0);
    check("R1 reg0 port B", rd_data_b, 32'h0);

    // R4: disabled write leaves target zero after reset
    @(negedge clk);
    drive(1'b0, 5'd9, 32'h1111_2222, 5'd3, 5'd4);
    @(negedge clk);
    drive(1'b0, 5'd0, 32'h0, 5'd9, 5'd9);
    #1;
    check("R4 disabled write", rd_data_a, 32'h0);
    check("R8 same address", rd_data_b, rd_data_a);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule